// File: doc/BRIEF.md
# Job Ring Slot Accounting Unit

This block keeps the bookkeeping for one pair of descriptor rings. Software fills the input ring, and hardware consumes its entries one at a time. Hardware fills the output ring with results, and software later retires them. Software never writes pointers. It reports work as counts: a number of jobs added to the input ring, or a number of entries removed from the output ring. The unit tracks how much room is left in the input ring, how many output slots are occupied, the input read index and the output write index. Both indices wrap at the programmed ring size.

A strobe from the job fetcher marks each input entry taken. A strobe from the result writer marks each completion. The unit raises a completion interrupt on each completion, or it can coalesce completions by a count threshold and a timeout. Count errors in either direction are reported in an interrupt status word with an error type, an error index and a halt state. A configuration bit stops the unit from accepting new consumption after an error until software resets the ring.

Top module: `jr_slot_acct`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: Register map by `reg_addr`: 0 input size, 1 room read / jobs-added write, 2 output size, 3 slots-full read / jobs-removed write, 4 interrupt status, 5 configuration, 6 input read index read / command write, 7 output write index. The size registers keep only bits 9..0 of a write. Room equals input size minus the jobs outstanding.
- R3: A jobs-added write raises the outstanding count by the value written. Each `job_taken` pulse lowers it by one and advances the read index, wrapping to 0 at the input size. A pulse while nothing is outstanding has no effect.
- R4: A jobs-added value larger than the room sets status bit 1, writes error type 9 to bits 11..8 and writes the value's low 14 bits to bits 29..16. The room is left unchanged, and the error stays set until a ring reset.
- R5: Each `job_done` pulse raises the slots-full count and advances the write index, wrapping at the output size. A pulse while the output ring is full has no effect.
- R6: A jobs-removed write lowers the slots-full count by the value written. A value larger than the slots full instead sets the error with type 8, stores the value as the index, and leaves the count unchanged.
- R7: With coalescing off (configuration bit 1 = 0), every accepted completion sets status bit 0. Writing 1 to status bit 0 clears it.
- R8: With coalescing on, status bit 0 sets on the completion that brings the pending completions to the count threshold (configuration bits 15..8, where 0 acts as 1). The pending count then restarts.
- R9: With coalescing on and completions pending, status bit 0 sets at the T-th clock edge after the edge that recorded the first pending completion. T is configuration bits 31..16, where 0 acts as 1.
- R10: Configuration bit 0 masks `irq` (`irq` = status bit 0 AND NOT mask). The mask has no effect on status bit 0.
- R11: With stop-on-error (configuration bit 2) set, a count error sets status bits 3..2 to 01 for one cycle, then to 10. From then until a ring reset, `job_taken` is ignored.
- R12: Writing 1 to bit 0 of address 6 resets the ring. This clears the counts, the indices, the pending completions and the status. The sizes and the configuration are kept. If input jobs were outstanding, the status instead reports error type 7 with the discarded count as the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| job_taken | input | 1 | One input-ring entry consumed |
| job_done | input | 1 | One result written into the output ring |
| irq | output | 1 | Completion interrupt after masking |

## Verification
The hardest state to reach is the halt window under stop-on-error. The bench has to build up outstanding jobs, provoke an oversize add to enter the one-cycle "in progress" halt code, and observe it on the very next cycle. It then shows that a consume pulse is ignored. Finally it resets the ring with jobs still outstanding, so that the reset-error report carries the discarded count. Timer coalescing is reached with a single completion and a threshold the count can never meet, and the status is sampled on both sides of the expiry edge.

// File: rtl/jr_pkg.sv
// Package: register map, status field positions and codes shared by the
// job ring slot accounting unit and its bench-facing documentation.
package jr_pkg;
    // Register addresses
    localparam logic [2:0] A_IN_SIZE  = 3'd0;
    localparam logic [2:0] A_IN_ROOM  = 3'd1;   // read room, write jobs added
    localparam logic [2:0] A_OUT_SIZE = 3'd2;
    localparam logic [2:0] A_OUT_FULL = 3'd3;   // read full, write jobs removed
    localparam logic [2:0] A_STATUS   = 3'd4;
    localparam logic [2:0] A_CONFIG   = 3'd5;
    localparam logic [2:0] A_RD_IDX   = 3'd6;   // read index, write command
    localparam logic [2:0] A_WR_IDX   = 3'd7;

    // Configuration bits
    localparam int CFG_MASK   = 0;
    localparam int CFG_COAL   = 1;
    localparam int CFG_SOE    = 2;
    localparam int CFG_CNT_LSB = 8;
    localparam int CFG_TMO_LSB = 16;

    // Status field positions
    localparam int ST_INT      = 0;
    localparam int ST_ERR      = 1;
    localparam int ST_HALT_LSB = 2;
    localparam int ST_TYPE_LSB = 8;
    localparam int ST_IDX_LSB  = 16;
    localparam int ERR_IDX_W   = 14;

    typedef enum logic [3:0] {
        ERR_NONE   = 4'd0,
        ERR_RESET  = 4'd7,
        ERR_RM_OVF = 4'd8,
        ERR_AD_OVF = 4'd9
    } err_type_t;

    typedef enum logic [1:0] {
        HALT_NONE = 2'b00,
        HALT_PROG = 2'b01,
        HALT_DONE = 2'b10
    } halt_t;
endpackage

// File: rtl/jr_in_ring.sv
// Input ring tracker: counts jobs outstanding in the input ring and walks
// the read index. Assumes add_cnt is only meaningful while add_vld is high
// and that the ring size is not shrunk below the outstanding count.
module jr_in_ring #(
    parameter int SIZE_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [SIZE_W-1:0] size,
    input  logic              add_vld,
    input  logic [DATA_W-1:0] add_cnt,
    input  logic              take,
    output logic [SIZE_W-1:0] room,
    output logic [SIZE_W-1:0] busy,
    output logic [SIZE_W-1:0] rd_idx,
    output logic              add_ovf
);
    logic              take_ok;
    logic              add_ok;
    logic [SIZE_W-1:0] add_amt;
    logic [SIZE_W:0]   idx_inc;

    // Room, overflow test and accepted-event qualification
    always_comb begin
        room    = (size > busy) ? (size - busy) : '0;
        add_ovf = add_vld && (add_cnt > {{(DATA_W-SIZE_W){1'b0}}, room});
        add_ok  = add_vld && !add_ovf;
        take_ok = take && (busy != '0);
        add_amt = add_ok ? add_cnt[SIZE_W-1:0] : '0;
        idx_inc = {1'b0, rd_idx} + 1'b1;
    end

    // Outstanding count and wrapping read index
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy   <= '0;
            rd_idx <= '0;
        end else begin
            busy <= busy + add_amt - {{(SIZE_W-1){1'b0}}, take_ok};
            if (take_ok)
                rd_idx <= (idx_inc >= {1'b0, size}) ? '0 : idx_inc[SIZE_W-1:0];
        end
    end

    AST_ADD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (add_ovf && !take_ok && !clr) |=> (busy == $past(busy))); // R4
    AST_EMPTY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && busy == '0 && !clr) |=> (rd_idx == $past(rd_idx))); // R3
endmodule

// File: rtl/jr_out_ring.sv
// Output ring tracker: counts occupied result slots and walks the write
// index. A completion arriving while the ring is full is dropped.
module jr_out_ring #(
    parameter int SIZE_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [SIZE_W-1:0] size,
    input  logic              done,
    input  logic              rm_vld,
    input  logic [DATA_W-1:0] rm_cnt,
    output logic [SIZE_W-1:0] full,
    output logic [SIZE_W-1:0] wr_idx,
    output logic              rm_ovf,
    output logic              done_acc
);
    logic              rm_ok;
    logic [SIZE_W-1:0] rm_amt;
    logic [SIZE_W:0]   idx_inc;

    // Acceptance of completions and removal requests
    always_comb begin
        done_acc = done && (full < size);
        rm_ovf   = rm_vld && (rm_cnt > {{(DATA_W-SIZE_W){1'b0}}, full});
        rm_ok    = rm_vld && !rm_ovf;
        rm_amt   = rm_ok ? rm_cnt[SIZE_W-1:0] : '0;
        idx_inc  = {1'b0, wr_idx} + 1'b1;
    end

    // Slots-full count and wrapping write index
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            full   <= '0;
            wr_idx <= '0;
        end else begin
            full <= full + {{(SIZE_W-1){1'b0}}, done_acc} - rm_amt;
            if (done_acc)
                wr_idx <= (idx_inc >= {1'b0, size}) ? '0 : idx_inc[SIZE_W-1:0];
        end
    end

    AST_RM_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_ovf && !done_acc && !clr) |=> (full == $past(full))); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full >= size && !rm_vld && !clr) |=> (full == $past(full))); // R5
endmodule

// File: rtl/jr_irq_coal.sv
// Completion interrupt generator: without coalescing, every accepted
// completion fires. With coalescing, the block fires on the count threshold
// or when the timeout expires with completions pending. A zero threshold
// acts as one.
module jr_irq_coal #(
    parameter int CNT_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             coal_en,
    input  logic [CNT_W-1:0] cnt_thr,
    input  logic [TMO_W-1:0] tmo_thr,
    input  logic             done_acc,
    output logic             fire
);
    localparam int PEND_W = CNT_W + 1;

    logic [PEND_W-1:0] pending;
    logic [PEND_W-1:0] pend_n;
    logic [TMO_W-1:0]  tmr;
    logic [CNT_W-1:0]  thr_eff;
    logic [TMO_W-1:0]  tmo_eff;
    logic              hit_cnt;
    logic              hit_tmo;

    // Threshold comparisons and fire decision
    always_comb begin
        thr_eff = (cnt_thr == '0) ? CNT_W'(1) : cnt_thr;
        tmo_eff = (tmo_thr == '0) ? TMO_W'(1) : tmo_thr;
        pend_n  = pending + {{(PEND_W-1){1'b0}}, done_acc};
        hit_cnt = done_acc && (pend_n >= {1'b0, thr_eff});
        hit_tmo = (pending != '0) && (({1'b0, tmr} + 1'b1) >= {1'b0, tmo_eff});
        fire    = coal_en ? (hit_cnt || hit_tmo) : done_acc;
    end

    // Pending completion count and timeout timer
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !coal_en || fire) begin
            pending <= '0;
            tmr     <= '0;
        end else begin
            pending <= pend_n;
            tmr     <= (pending != '0) ? tmr + 1'b1 : '0;
        end
    end

    AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pending == '0)); // R8
endmodule

// File: rtl/jr_slot_acct.sv
// Job ring slot accounting unit, top level: register decode, sizes and
// configuration, error/halt status and interrupt output. Assumes a single
// register write per cycle, so no add and remove arrive together.
module jr_slot_acct
    import jr_pkg::*;
#(
    parameter int SIZE_W = 10,
    parameter int CNT_W  = 8,
    parameter int TMO_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        job_taken,
    input  logic        job_done,
    output logic        irq
);
    localparam int DATA_W = 32;

    logic [SIZE_W-1:0]    in_size_q, out_size_q;
    logic [DATA_W-1:0]    cfg_q;
    logic                 int_q, err_q;
    err_type_t            etype_q;
    logic [ERR_IDX_W-1:0] eidx_q;
    halt_t                halt_q;

    logic                 wr_add, wr_rm, wr_cmd, clr, take_en;
    logic [SIZE_W-1:0]    room, busy, rd_idx, full, wr_idx;
    logic                 add_ovf, rm_ovf, done_acc, fire;
    logic [DATA_W-1:0]    status;

    // Register write decode
    always_comb begin
        wr_add  = reg_wr && (reg_addr == A_IN_ROOM);
        wr_rm   = reg_wr && (reg_addr == A_OUT_FULL);
        wr_cmd  = reg_wr && (reg_addr == A_RD_IDX);
        clr     = wr_cmd && reg_wdata[0];
        take_en = job_taken && (halt_q == HALT_NONE);
    end

    jr_in_ring #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n), .clr(clr), .size(in_size_q),
        .add_vld(wr_add), .add_cnt(reg_wdata), .take(take_en),
        .room(room), .busy(busy), .rd_idx(rd_idx), .add_ovf(add_ovf)
    );

    jr_out_ring #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clr(clr), .size(out_size_q),
        .done(job_done), .rm_vld(wr_rm), .rm_cnt(reg_wdata),
        .full(full), .wr_idx(wr_idx), .rm_ovf(rm_ovf), .done_acc(done_acc)
    );

    jr_irq_coal #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .coal_en(cfg_q[CFG_COAL]),
        .cnt_thr(cfg_q[CFG_CNT_LSB +: CNT_W]),
        .tmo_thr(cfg_q[CFG_TMO_LSB +: TMO_W]),
        .done_acc(done_acc), .fire(fire)
    );

    // Ring sizes and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_size_q  <= '0;
            out_size_q <= '0;
            cfg_q      <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_IN_SIZE:  in_size_q  <= reg_wdata[SIZE_W-1:0];
                A_OUT_SIZE: out_size_q <= reg_wdata[SIZE_W-1:0];
                A_CONFIG:   cfg_q      <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Error report: latest count error, or reset-discard report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            etype_q <= ERR_NONE;
            eidx_q  <= '0;
        end else if (clr) begin
            err_q   <= (busy != '0);
            etype_q <= (busy != '0) ? ERR_RESET : ERR_NONE;
            eidx_q  <= ERR_IDX_W'(busy);
        end else if (add_ovf || rm_ovf) begin
            err_q   <= 1'b1;
            etype_q <= add_ovf ? ERR_AD_OVF : ERR_RM_OVF;
            eidx_q  <= reg_wdata[ERR_IDX_W-1:0];
        end
    end

    // Halt state under stop-on-error
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            halt_q <= HALT_NONE;
        else if (halt_q == HALT_PROG)
            halt_q <= HALT_DONE;
        else if ((add_ovf || rm_ovf) && cfg_q[CFG_SOE] && halt_q == HALT_NONE)
            halt_q <= HALT_PROG;
    end

    // Interrupt status bit: set on fire, write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            int_q <= 1'b0;
        else if (fire)
            int_q <= 1'b1;
        else if (reg_wr && reg_addr == A_STATUS && reg_wdata[ST_INT])
            int_q <= 1'b0;
    end

    // Status word assembly and read mux
    always_comb begin
        status = '0;
        status[ST_INT] = int_q;
        status[ST_ERR] = err_q;
        status[ST_HALT_LSB +: 2] = halt_q;
        status[ST_TYPE_LSB +: 4] = etype_q;
        status[ST_IDX_LSB +: ERR_IDX_W] = eidx_q;
        case (reg_addr)
            A_IN_SIZE:  reg_rdata = DATA_W'(in_size_q);
            A_IN_ROOM:  reg_rdata = DATA_W'(room);
            A_OUT_SIZE: reg_rdata = DATA_W'(out_size_q);
            A_OUT_FULL: reg_rdata = DATA_W'(full);
            A_STATUS:   reg_rdata = status;
            A_CONFIG:   reg_rdata = cfg_q;
            A_RD_IDX:   reg_rdata = DATA_W'(rd_idx);
            default:    reg_rdata = DATA_W'(wr_idx);
        endcase
        irq = int_q && !cfg_q[CFG_MASK];
    end

    AST_HALT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q == HALT_PROG && !clr) |=> (halt_q == HALT_DONE)); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr) |=> err_q); // R4
    AST_HALT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q != HALT_NONE && !clr && !wr_add) |=> (busy == $past(busy))); // R11
endmodule

// File: tb/tb_jr_slot_acct.sv
`timescale 1ns/1ps
module tb_jr_slot_acct;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        job_taken = 1'b0;
    logic        job_done = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    jr_slot_acct dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .job_taken(job_taken),
        .job_done(job_done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse_take();
        @(negedge clk); job_taken = 1'b1;
        @(negedge clk); job_taken = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); job_done = 1'b1;
        @(negedge clk); job_done = 1'b0;
    endtask

    task automatic ring_reset();
        wr(3'd6, 32'h1);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_check("R1 reg", 3'(a), 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_sizes();
        wr(3'd0, 32'hFFFF_F404);
        rd_check("R2 size mask", 3'd0, 32'h004);
        wr(3'd2, 32'd3);
        rd_check("R2 out size", 3'd2, 32'd3);
        rd_check("R2 room", 3'd1, 32'd4);
    endtask

    task automatic t_add_consume();
        wr(3'd1, 32'd3);
        rd_check("R3 room after add", 3'd1, 32'd1);
        pulse_take(); pulse_take();
        rd_check("R3 rd idx", 3'd6, 32'd2);
        rd_check("R3 room", 3'd1, 32'd3);
        wr(3'd1, 32'd3);
        rd_check("R2 room zero", 3'd1, 32'd0);
        for (int i = 0; i < 4; i++) pulse_take();
        rd_check("R3 wrap idx", 3'd6, 32'd2);
        pulse_take();
        rd_check("R3 empty take idx", 3'd6, 32'd2);
        rd_check("R3 empty take room", 3'd1, 32'd4);
    endtask

    task automatic t_add_ovf();
        wr(3'd1, 32'd5);
        rd_check("R4 status", 3'd4, 32'h0005_0902);
        rd_check("R4 room kept", 3'd1, 32'd4);
        ring_reset();
        rd_check("R12 status clear", 3'd4, 32'h0);
        rd_check("R12 idx clear", 3'd6, 32'h0);
        rd_check("R12 size kept", 3'd0, 32'd4);
    endtask

    task automatic t_complete();
        pulse_done(); pulse_done();
        rd_check("R5 full", 3'd3, 32'd2);
        rd_check("R5 wr idx", 3'd7, 32'd2);
        rd_check("R7 int set", 3'd4, 32'h1);
        wr(3'd4, 32'h1);
        rd_check("R7 w1c", 3'd4, 32'h0);
        pulse_done(); pulse_done();
        rd_check("R5 full cap", 3'd3, 32'd3);
        rd_check("R5 idx wrap", 3'd7, 32'd0);
        wr(3'd3, 32'd4);
        rd_check("R6 status", 3'd4, 32'h0004_0803);
        rd_check("R6 full kept", 3'd3, 32'd3);
        wr(3'd3, 32'd2);
        rd_check("R6 remove", 3'd3, 32'd1);
        ring_reset();
        rd_check("R12 full clear", 3'd3, 32'd0);
    endtask

    task automatic t_mask();
        wr(3'd5, 32'h1);
        pulse_done();
        rd_check("R10 status bit", 3'd4, 32'h1);
        check("R10 irq masked", {31'd0, irq}, 32'h0);
        wr(3'd5, 32'h0);
        check("R10 irq unmasked", {31'd0, irq}, 32'h1);
        ring_reset();
        check("R12 irq clear", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_coal_cnt();
        wr(3'd5, 32'hFFFF_0302);
        pulse_done(); pulse_done();
        rd_check("R8 below thr", 3'd4, 32'h0);
        pulse_done();
        rd_check("R8 at thr", 3'd4, 32'h1);
        check("R8 irq", {31'd0, irq}, 32'h1);
        ring_reset();
    endtask

    task automatic t_timer();
        wr(3'd5, 32'h0006_0502);
        pulse_done();
        repeat (5) @(negedge clk);
        rd_check("R9 before expiry", 3'd4, 32'h0);
        @(negedge clk);
        rd_check("R9 at expiry", 3'd4, 32'h1);
        ring_reset();
    endtask

    task automatic t_soe();
        wr(3'd5, 32'h4);
        wr(3'd1, 32'd2);
        wr(3'd1, 32'd5);
        rd_check("R11 halt progress", 3'd4, 32'h0005_0906);
        @(negedge clk);
        rd_check("R11 halt done", 3'd4, 32'h0005_090A);
        pulse_take();
        rd_check("R11 take ignored", 3'd1, 32'd2);
        ring_reset();
        rd_check("R12 reset error", 3'd4, 32'h0002_0702);
        rd_check("R12 room", 3'd1, 32'd4);
        wr(3'd1, 32'd1);
        pulse_take();
        rd_check("R11 take resumes", 3'd6, 32'd1);
        rd_check("R12 cfg kept", 3'd5, 32'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sizes();
        t_add_consume();
        t_add_ovf();
        t_complete();
        t_mask();
        t_coal_cnt();
        t_timer();
        t_soe();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule